// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block produces the word address stream for a multi-register load or store. When it is idle, a one-cycle start request captures a 32-bit base value, a 16-bit register-select mask and three mode bits: pre/post, up/down and writeback. From these it works out how many registers are selected, where the transfer window begins, and what the base register must hold once the transfer ends. It then presents one beat for each selected register. Each beat pairs a word address with the index of the register that goes with it.

Beats go out under a valid/ready handshake, one beat for each accepted transfer. They always run from the lowest address of the window to the highest, even when the window lies below the base. The lowest-numbered selected register is paired with the lowest address. The final base value is on its own output for the whole transfer. A done flag marks the last beat. A transfer with an empty mask produces no beats and only a single done cycle.

Top module: `blkx_addr_seq`

## Requirements
- R1: While reset is active and after it is released, beat_valid_o, done_o and busy_o are 0 until a start is accepted.
- R2: A start is accepted when start_i is high on a clock edge while busy_o is 0. From the next cycle the first beat address is shown. With M equal to the number of set mask bits, that address is base-4M+4 for {pre_i,up_i}=00, base for 01, base-4M for 10 and base+4 for 11.
- R3: Each beat accepted with beat_valid_o and beat_ready_i both high is followed by a beat whose address is exactly 4 higher.
- R4: beat_reg_o carries the 4-bit index of a selected mask bit. Indices appear in ascending order, so the lowest selected index goes with the lowest address.
- R5: wb_base_o equals base when wb_i=0. When wb_i=1 it equals base+4M if up_i=1 and base-4M if up_i=0. It is valid from the first cycle after the start.
- R6: done_o is high together with the last beat and stays high until that beat is accepted. The cycle after that, beat_valid_o, done_o and busy_o are all 0.
- R7: While beat_valid_o is high and beat_ready_i is low, beat_valid_o, beat_addr_o and beat_reg_o keep their values.
- R8: A start with an all-zero mask gives exactly one cycle with done_o=1 and beat_valid_o=0, with wb_base_o equal to base. After that cycle the block is idle.
- R9: start_i is ignored while busy_o is 1. The beat stream and wb_base_o continue unchanged.
- R10: All address and writeback arithmetic wraps modulo 2^32.
- R11: wb_base_o does not change in the cycle that follows a cycle in which done_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start request, sampled while idle |
| base_i | input | 32 | Base register value |
| mask_i | input | 16 | Register-select mask |
| pre_i | input | 1 | 1 = base word excluded (before), 0 = included (after) |
| up_i | input | 1 | 1 = window above base, 0 = below |
| wb_i | input | 1 | 1 = report an updated base, 0 = report the original base |
| beat_valid_o | output | 1 | A beat is presented |
| beat_ready_i | input | 1 | Consumer accepts the presented beat |
| beat_addr_o | output | 32 | Word address of the beat |
| beat_reg_o | output | 4 | Register index paired with the beat |
| done_o | output | 1 | Last beat, or the single done cycle of an empty transfer |
| wb_base_o | output | 32 | Final base value |
| busy_o | output | 1 | Transfer in progress |

## Verification
Two events can fall in the same cycle. A new start can arrive while a beat is still pending, and the last beat can coincide with the done flag. The bench provokes the first case by raising start_i with a different base during a stalled middle beat. It then judges that the remaining addresses, register indices and wb_base_o match the values predicted for the original transfer. For the second case it checks, on every beat, that done_o is high on exactly the final one. It also checks that done_o stays high through a stall on that beat and clears, with busy_o, one cycle after acceptance.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_EMPTY = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    WIN_DEC_AFTER  = 2'b00,
    WIN_INC_AFTER  = 2'b01,
    WIN_DEC_BEFORE = 2'b10,
    WIN_INC_BEFORE = 2'b11
  } win_mode_e;
endpackage

// File: rtl/blkx_rst_sync.sv
module blkx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/blkx_popcount.sv
module blkx_popcount #(
  parameter int NREG = 16,
  localparam int CNT_W = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0]  bits_i,
  output logic [CNT_W-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < NREG; i++) begin
      count_o = count_o + CNT_W'(bits_i[i]);
    end
  end
endmodule

// File: rtl/blkx_lowbit.sv
module blkx_lowbit #(
  parameter int NREG = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  bits_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             only_o,
  output logic [NREG-1:0]  rest_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (bits_i[i]) idx_o = IDX_W'(i);
    end
    rest_o = bits_i & (bits_i - NREG'(1));
    only_o = (bits_i != '0) && (rest_o == '0);
  end
endmodule

// File: rtl/blkx_bounds.sv
module blkx_bounds
  import blkx_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int CNT_W = $clog2(NREG + 1)
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              pre_i,
  input  logic              up_i,
  input  logic              wb_i,
  output logic [ADDR_W-1:0] first_o,
  output logic [ADDR_W-1:0] final_o
);
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] word;
  win_mode_e         mode;

  assign span = ADDR_W'(count_i) * ADDR_W'(WORD_BYTES);
  assign word = ADDR_W'(WORD_BYTES);
  assign mode = win_mode_e'({pre_i, up_i});

  always_comb begin
    unique case (mode)
      WIN_DEC_AFTER:  first_o = base_i - span + word;
      WIN_INC_AFTER:  first_o = base_i;
      WIN_DEC_BEFORE: first_o = base_i - span;
      default:        first_o = base_i + word;
    endcase
    if (!wb_i)     final_o = base_i;
    else if (up_i) final_o = base_i + span;
    else           final_o = base_i - span;
  end
endmodule

// File: rtl/blkx_addr_seq.sv
module blkx_addr_seq
  import blkx_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int CNT_W = $clog2(NREG + 1),
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [NREG-1:0]   mask_i,
  input  logic              pre_i,
  input  logic              up_i,
  input  logic              wb_i,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic [IDX_W-1:0]  beat_reg_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] wb_base_o,
  output logic              busy_o
);
  logic rst_n_sync;

  blkx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [NREG-1:0]   rem_q, rem_d;
  logic [ADDR_W-1:0] wb_q, wb_d;

  logic [CNT_W-1:0]  sel_count;
  logic [ADDR_W-1:0] first_addr;
  logic [ADDR_W-1:0] final_base;
  logic [IDX_W-1:0]  low_idx;
  logic              low_only;
  logic [NREG-1:0]   low_rest;

  blkx_popcount #(.NREG(NREG)) u_cnt (
    .bits_i  (mask_i),
    .count_o (sel_count)
  );

  blkx_bounds #(.ADDR_W(ADDR_W), .NREG(NREG), .WORD_BYTES(WORD_BYTES)) u_bounds (
    .base_i  (base_i),
    .count_i (sel_count),
    .pre_i   (pre_i),
    .up_i    (up_i),
    .wb_i    (wb_i),
    .first_o (first_addr),
    .final_o (final_base)
  );

  blkx_lowbit #(.NREG(NREG)) u_low (
    .bits_i (rem_q),
    .idx_o  (low_idx),
    .only_o (low_only),
    .rest_o (low_rest)
  );

  logic accept_start;
  logic accept_beat;
  logic load_en;
  logic step_en;

  assign accept_start = (state_q == SEQ_IDLE) && start_i;
  assign accept_beat  = (state_q == SEQ_RUN) && beat_ready_i;
  assign load_en      = accept_start;
  assign step_en      = accept_beat;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    wb_d    = wb_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (load_en) begin
          addr_d  = first_addr;
          rem_d   = mask_i;
          wb_d    = final_base;
          state_d = (mask_i == '0) ? SEQ_EMPTY : SEQ_RUN;
        end
      end
      SEQ_RUN: begin
        if (step_en) begin
          addr_d = addr_q + ADDR_W'(WORD_BYTES);
          rem_d  = low_rest;
          if (low_only) state_d = SEQ_IDLE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) state_q <= SEQ_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (load_en || step_en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
    if (load_en) wb_q <= wb_d;
  end

  assign beat_valid_o = (state_q == SEQ_RUN);
  assign beat_addr_o  = addr_q;
  assign beat_reg_o   = low_idx;
  assign done_o       = ((state_q == SEQ_RUN) && low_only) || (state_q == SEQ_EMPTY);
  assign wb_base_o    = wb_q;
  assign busy_o       = (state_q != SEQ_IDLE);

  // R3: an accepted non-final beat is followed by one 4 bytes higher
  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n_sync)
    beat_valid_o && beat_ready_i && !done_o |=>
      beat_valid_o && (beat_addr_o == $past(beat_addr_o) + ADDR_W'(WORD_BYTES)));

  // R6: accepting the final beat returns the block to idle
  a_r6_done_last: assert property (@(posedge clk) disable iff (!rst_n_sync)
    done_o && beat_valid_o && beat_ready_i |=> !beat_valid_o && !done_o && !busy_o);

  // R7: a stalled beat holds its address and register index
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n_sync)
    beat_valid_o && !beat_ready_i |=>
      beat_valid_o && $stable(beat_addr_o) && $stable(beat_reg_o));

  // R8: the done cycle of an empty transfer lasts one cycle
  a_r8_empty_once: assert property (@(posedge clk) disable iff (!rst_n_sync)
    done_o && !beat_valid_o |=> !done_o && !busy_o);

  // R9: a start during a transfer leaves the writeback value alone
  a_r9_ignore_start: assert property (@(posedge clk) disable iff (!rst_n_sync)
    busy_o && start_i |=> $stable(wb_base_o));

  // R11: writeback value is unchanged right after done
  a_r11_wb_stable: assert property (@(posedge clk) disable iff (!rst_n_sync)
    done_o |=> $stable(wb_base_o));

  // R1: done never appears without a busy transfer
  a_r1_done_busy: assert property (@(posedge clk) disable iff (!rst_n_sync)
    done_o |-> busy_o);
endmodule

// File: tb/test_blkx_addr_seq.sv
module test_blkx_addr_seq;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] base_i;
  logic [15:0] mask_i;
  logic        pre_i, up_i, wb_i;
  logic        beat_valid_o;
  logic        beat_ready_i;
  logic [31:0] beat_addr_o;
  logic [3:0]  beat_reg_o;
  logic        done_o;
  logic [31:0] wb_base_o;
  logic        busy_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  blkx_addr_seq i_blkx_addr_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .base_i       (base_i),
    .mask_i       (mask_i),
    .pre_i        (pre_i),
    .up_i         (up_i),
    .wb_i         (wb_i),
    .beat_valid_o (beat_valid_o),
    .beat_ready_i (beat_ready_i),
    .beat_addr_o  (beat_addr_o),
    .beat_reg_o   (beat_reg_o),
    .done_o       (done_o),
    .wb_base_o    (wb_base_o),
    .busy_o       (busy_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // fields: base[31:0], mask[15:0], pre, up, wb, stall, poke
  localparam int NVEC = 9;
  localparam logic [52:0] VEC [NVEC] = '{
    {32'h0000_1000, 16'h00F0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {32'h0000_2000, 16'h8001, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {32'h0000_3000, 16'h0A50, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {32'h0000_4000, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'h0000_5000, 16'h0003, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h0000_0004, 16'h000F, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'hFFFF_FFF8, 16'h0007, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {32'h0000_6000, 16'h4000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {32'h0000_7000, 16'h1248, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [31:0] b, input logic [15:0] m,
                          input bit p, input bit u, input bit w,
                          input bit stall, input bit poke);
    int cnt;
    int n;
    logic [31:0] span, first, fin;
    cnt = 0;
    for (int i = 0; i < 16; i++) if (m[i]) cnt++;
    span = 32'(cnt) * 32'd4;
    case ({p, u})
      2'b00:   first = b - span + 32'd4;
      2'b01:   first = b;
      2'b10:   first = b - span;
      default: first = b + 32'd4;
    endcase
    fin = !w ? b : (u ? b + span : b - span);

    @(negedge clk);
    start_i = 1'b1; base_i = b; mask_i = m; pre_i = p; up_i = u; wb_i = w;
    beat_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;

    if (cnt == 0) begin
      chk(done_o && !beat_valid_o, "R8 empty done", {30'd0, done_o, beat_valid_o}, 32'd2);
      chk(wb_base_o == b, "R8 empty wb", wb_base_o, b);
      @(negedge clk);
      chk(!done_o && !busy_o, "R8 empty idle", {30'd0, done_o, busy_o}, 32'd0);
      return;
    end

    n = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        if ((stall && n % 2 == 1) || (poke && n == 1)) begin
          beat_ready_i = 1'b0;
          if (poke) begin
            start_i = 1'b1; base_i = ~b; mask_i = 16'h0001;
          end
          @(negedge clk);
          start_i = 1'b0; base_i = b; mask_i = m;
          chk(beat_valid_o && beat_addr_o == first + 32'(4 * n), "R7 stall hold addr",
              beat_addr_o, first + 32'(4 * n));
          chk(beat_reg_o == 4'(i), "R7 stall hold reg", 32'(beat_reg_o), 32'(i));
          if (poke) chk(wb_base_o == fin, "R9 start while busy", wb_base_o, fin);
        end
        chk(beat_valid_o, "R6 beat present", {31'd0, beat_valid_o}, 32'd1);
        chk(beat_addr_o == first + 32'(4 * n), (n == 0) ? "R2 first addr" : "R3 R10 next addr",
            beat_addr_o, first + 32'(4 * n));
        chk(beat_reg_o == 4'(i), "R4 reg index", 32'(beat_reg_o), 32'(i));
        chk(done_o == (n == cnt - 1), "R6 done on last", {31'd0, done_o}, 32'(n == cnt - 1));
        if (n == cnt - 1) chk(wb_base_o == fin, "R5 R10 writeback", wb_base_o, fin);
        beat_ready_i = 1'b1;
        @(negedge clk);
        beat_ready_i = 1'b0;
        if (n == cnt - 1)
          chk(wb_base_o == fin, "R11 wb after done", wb_base_o, fin);
        n++;
      end
    end
    chk(!beat_valid_o && !done_o && !busy_o, "R6 idle after last",
        {29'd0, beat_valid_o, done_o, busy_o}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; base_i = '0; mask_i = '0;
    pre_i = 1'b0; up_i = 1'b0; wb_i = 1'b0; beat_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!beat_valid_o && !done_o && !busy_o, "R1 in reset",
        {29'd0, beat_valid_o, done_o, busy_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!beat_valid_o && !done_o && !busy_o, "R1 after reset",
        {29'd0, beat_valid_o, done_o, busy_o}, 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      run_xfer(VEC[v][52:21], VEC[v][20:5], VEC[v][4], VEC[v][3], VEC[v][2],
               VEC[v][1], VEC[v][0]);
    end

    // R8: empty mask in every mode
    for (int md = 0; md < 8; md++) begin
      run_xfer(32'h0000_8000 + 32'(md * 64), 16'h0000, md[2], md[1], md[0], 1'b0, 1'b0);
    end

    // R10: decrement-before across zero with writeback wrap
    run_xfer(32'h0000_0008, 16'h00FF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    // R9: poke during an incrementing-before transfer
    run_xfer(32'h0000_9000, 16'h0E00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule